// File: doc/BRIEF.md
# Sampling Converter Bus Controller

This block is the clocked digital front of a multiplexed sampling converter. A host sees it as a memory-like port: an active-low chip select qualifies an active-low sample/hold strobe and an active-low read strobe, and two select bits pick one of four analog inputs. The controller latches the channel when a sample request is accepted. It drives a coarse-phase strobe and then a fine-phase strobe to the conversion core, latches the core's result word when the fine phase ends, and flags completion on an active-low interrupt that the host clears by ending a read.

Two operating modes are chosen by a static configuration input. In pulse mode the width of the host's sample/hold pulse sets the coarse phase, and a cycle counter times the fine phase that follows its release. In read mode the host ties sample/hold to read. Both phases are then timed by counters from the start of the request, and while the conversion runs the bus keeps showing the previous result. The analog core lies outside the block and supplies its result on a plain input.

Top module: `sconv_bus_ctrl`

## Requirements
- R1: A sample request is accepted only while cs_n and sh_n are both low; with cs_n high, holding sh_n low starts nothing (coarse_stb stays 0, chan unchanged).
- R2: On an accepted request chan takes chsel (00 input 0, 01 input 1, 10 input 2, 11 input 3) and holds it, whatever chsel does, until the next accepted request.
- R3: In pulse mode (mode_rd=0), coarse_stb is high from the cycle after acceptance until the clock edge that sees the gated sample strobe released; fine_stb is then high for T1_FINE_CYC cycles.
- R4: In pulse mode, int_n falls T1_FINE_CYC cycles after the edge that sees the release, at the edge where fine_stb falls, and the core_result sampled at that edge becomes the bus value.
- R5: In read mode (mode_rd=1), coarse_stb is high for T2_COARSE_CYC cycles after acceptance, then fine_stb for T2_FINE_CYC cycles; int_n falls and the result is latched at the edge that ends the fine phase.
- R6: int_n stays low while a read is held and goes high at the first clock edge that sees the gated read end (rd_n or cs_n rising while both were low).
- R7: db_oe is high exactly while cs_n and rd_n are both low; db_out is all zeros whenever db_oe is low.
- R8: While a read-mode conversion is in progress with the bus enabled, db_out keeps the previous result until the new one is latched.
- R9: A sample request that arrives while a conversion is in progress is ignored: chan and the phase timing of the running conversion are unchanged, and no conversion follows from it.
- R10: After reset int_n is high, both strobes are low, chan is 0 and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rd | input | 1 | Static mode: 0 pulse mode, 1 read mode |
| cs_n | input | 1 | Active-low chip select |
| sh_n | input | 1 | Active-low sample/hold strobe |
| rd_n | input | 1 | Active-low read strobe |
| chsel | input | SEL_W | Channel select, captured on an accepted request |
| core_result | input | DATA_W | Result word from the conversion core |
| chan | output | SEL_W | Channel held for the current conversion |
| coarse_stb | output | 1 | High during the coarse phase |
| fine_stb | output | 1 | High during the fine phase |
| int_n | output | 1 | Active-low conversion-complete flag |
| db_out | output | DATA_W | Data bus value |
| db_oe | output | 1 | Data bus output enable |

## Verification
The hardest situation to reach is a second sample request landing inside a running conversion, because in pulse mode the strobe is held low for the whole coarse phase and a fresh falling edge cannot occur there. The stimulus therefore uses read mode. There the counters run regardless of the pins, so the bench lifts and lowers the tied strobes a few cycles into the conversion with a different channel select. It then checks that the channel, the interrupt timing and the latched value all follow the first request, and that no conversion starts after the first one ends.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COARSE = 2'd1,
      ST_FINE   = 2'd2
   } conv_st_e;

endpackage

// File: rtl/sconv_edge.sv
// Registers a gated active-high strobe and reports its start and end edges.
module sconv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   output logic starts,
   output logic ends
);

   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign starts = act & ~act_q;
   assign ends   = ~act & act_q;

endmodule

// File: rtl/sconv_seq.sv
// Conversion phase sequencer: channel capture and coarse/fine phase timing.
module sconv_seq
   import sconv_pkg::*;
#(
   parameter int SEL_W         = 2,
   parameter int T1_FINE_CYC   = 18,
   parameter int T2_COARSE_CYC = 8,
   parameter int T2_FINE_CYC   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_rd,
   input  logic             samp_start,
   input  logic             samp_rel,
   input  logic [SEL_W-1:0] chsel,
   output logic [SEL_W-1:0] chan,
   output logic             coarse_stb,
   output logic             fine_stb,
   output logic             latch_pls
);

   localparam int MAX_A   = (T1_FINE_CYC > T2_FINE_CYC) ? T1_FINE_CYC : T2_FINE_CYC;
   localparam int MAX_CYC = (MAX_A > T2_COARSE_CYC) ? MAX_A : T2_COARSE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] LD_T1F = CNT_W'(T1_FINE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_T2C = CNT_W'(T2_COARSE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_T2F = CNT_W'(T2_FINE_CYC - 1);

   if (T1_FINE_CYC < 1 || T2_COARSE_CYC < 1 || T2_FINE_CYC < 1) begin : g_bad_timing
      $error("sconv_seq: every phase needs at least one cycle");
   end

   conv_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic             cnt_done;

   assign cnt_done = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         chan <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (samp_start) begin
                  chan <= chsel;
                  st   <= ST_COARSE;
                  cnt  <= LD_T2C;
               end
            end
            ST_COARSE: begin
               if (mode_rd) begin
                  if (cnt_done) begin
                     st  <= ST_FINE;
                     cnt <= LD_T2F;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end else if (samp_rel) begin
                  st  <= ST_FINE;
                  cnt <= LD_T1F;
               end
            end
            ST_FINE: begin
               if (cnt_done) st  <= ST_IDLE;
               else          cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign coarse_stb = (st == ST_COARSE);
   assign fine_stb   = (st == ST_FINE);
   assign latch_pls  = (st == ST_FINE) && cnt_done;

   // A coarse phase may only begin from an idle sequencer.
   assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coarse_stb) |-> ($past(st) == ST_IDLE));

   // The held channel moves only on an accepted request.
   assert_chan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(samp_start && (st == ST_IDLE)) |=> $stable(chan));

   // Read mode: the fine phase follows a coarse phase whose count ran out.
   assert_rd_coarse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && coarse_stb && !cnt_done) |=> coarse_stb);

endmodule

// File: rtl/sconv_result_port.sv
// Result latch, completion flag and data bus drive.
module sconv_result_port #(
   parameter int DATA_W        = 10,
   parameter bit BUS_IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_pls,
   input  logic [DATA_W-1:0] core_result,
   input  logic              rd_act,
   input  logic              rd_end,
   output logic              int_n,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe
);

   logic [DATA_W-1:0] result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         int_n    <= 1'b1;
      end else if (latch_pls) begin
         result_q <= core_result;
         int_n    <= 1'b0;
      end else if (rd_end) begin
         int_n    <= 1'b1;
      end
   end

   assign db_oe = rd_act;

   if (BUS_IDLE_ZERO) begin : g_bus_zero
      assign db_out = rd_act ? result_q : '0;
   end else begin : g_bus_hold
      assign db_out = result_q;
   end

   // A finished read releases the flag unless a new result lands the same cycle.
   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && !latch_pls) |=> int_n);

   // The flag only drops with a freshly latched result.
   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(latch_pls));

endmodule

// File: rtl/sconv_bus_ctrl.sv
// Bus interface controller for a multiplexed sampling converter.
module sconv_bus_ctrl #(
   parameter int DATA_W        = 10,
   parameter int SEL_W         = 2,
   parameter int T1_FINE_CYC   = 18,
   parameter int T2_COARSE_CYC = 8,
   parameter int T2_FINE_CYC   = 16,
   parameter bit BUS_IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_rd,
   input  logic              cs_n,
   input  logic              sh_n,
   input  logic              rd_n,
   input  logic [SEL_W-1:0]  chsel,
   input  logic [DATA_W-1:0] core_result,
   output logic [SEL_W-1:0]  chan,
   output logic              coarse_stb,
   output logic              fine_stb,
   output logic              int_n,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe
);

   if (DATA_W < 1 || SEL_W < 1) begin : g_bad_width
      $error("sconv_bus_ctrl: widths must be positive");
   end

   logic samp_act, rd_act;
   logic samp_start, samp_rel;
   logic rd_start, rd_end;
   logic latch_pls;

   // Chip select qualifies both host strobes.
   assign samp_act = ~cs_n & ~sh_n;
   assign rd_act   = ~cs_n & ~rd_n;

   sconv_edge u_samp_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (samp_act),
      .starts (samp_start),
      .ends   (samp_rel)
   );

   sconv_edge u_rd_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (rd_act),
      .starts (rd_start),
      .ends   (rd_end)
   );

   sconv_seq #(
      .SEL_W         (SEL_W),
      .T1_FINE_CYC   (T1_FINE_CYC),
      .T2_COARSE_CYC (T2_COARSE_CYC),
      .T2_FINE_CYC   (T2_FINE_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_rd    (mode_rd),
      .samp_start (samp_start),
      .samp_rel   (samp_rel),
      .chsel      (chsel),
      .chan       (chan),
      .coarse_stb (coarse_stb),
      .fine_stb   (fine_stb),
      .latch_pls  (latch_pls)
   );

   sconv_result_port #(
      .DATA_W        (DATA_W),
      .BUS_IDLE_ZERO (BUS_IDLE_ZERO)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .latch_pls   (latch_pls),
      .core_result (core_result),
      .rd_act      (rd_act),
      .rd_end      (rd_end),
      .int_n       (int_n),
      .db_out      (db_out),
      .db_oe       (db_oe)
   );

   // Without chip select an idle controller stays idle.
   assert_cs_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !coarse_stb && !fine_stb) |=> !coarse_stb);

   // End of the fine phase and the completion flag coincide.
   assert_fine_end_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fine_stb) |-> !int_n);

   // An enabled bus holds its value unless a result was just latched.
   assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (db_oe && $past(db_oe) && !$past(latch_pls)) |-> $stable(db_out));

   // Strobes never overlap.
   assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(coarse_stb && fine_stb));

endmodule

// File: tb/tb_sconv_bus_ctrl.sv
module tb_sconv_bus_ctrl;

   localparam int CLK_PERIOD = 20;
   localparam int DATA_W = 10;
   localparam int SEL_W  = 2;
   localparam int T1F = 18;
   localparam int T2C = 8;
   localparam int T2F = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_rd = 1'b0;
   logic              cs_n = 1'b1;
   logic              sh_n = 1'b1;
   logic              rd_n = 1'b1;
   logic [SEL_W-1:0]  chsel = '0;
   logic [DATA_W-1:0] core_result = '0;
   logic [SEL_W-1:0]  chan;
   logic              coarse_stb, fine_stb, int_n, db_oe;
   logic [DATA_W-1:0] db_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sconv_bus_ctrl #(
      .DATA_W        (DATA_W),
      .SEL_W         (SEL_W),
      .T1_FINE_CYC   (T1F),
      .T2_COARSE_CYC (T2C),
      .T2_FINE_CYC   (T2F),
      .BUS_IDLE_ZERO (1'b1)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_rd     (mode_rd),
      .cs_n        (cs_n),
      .sh_n        (sh_n),
      .rd_n        (rd_n),
      .chsel       (chsel),
      .core_result (core_result),
      .chan        (chan),
      .coarse_stb  (coarse_stb),
      .fine_stb    (fine_stb),
      .int_n       (int_n),
      .db_out      (db_out),
      .db_oe       (db_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      tick(2);
      chk("R10 int_n", 32'(int_n), 1);
      chk("R10 coarse", 32'(coarse_stb), 0);
      chk("R10 fine", 32'(fine_stb), 0);
      chk("R10 chan", 32'(chan), 0);
      rst_n = 1'b1;
      tick(1);
      cs_n = 1'b0; rd_n = 1'b0;
      #1;
      chk("R10 result", 32'(db_out), 0);
      chk("R7 oe on", 32'(db_oe), 1);
      tick(1);
      rd_n = 1'b1; cs_n = 1'b1;
      tick(1);
   endtask

   task automatic t_gate_cs;
      mode_rd = 1'b0;
      chsel = 2'b11;
      sh_n = 1'b0; rd_n = 1'b0;
      tick(3);
      chk("R1 no start", 32'(coarse_stb), 0);
      chk("R1 chan", 32'(chan), 0);
      chk("R7 oe off", 32'(db_oe), 0);
      chk("R7 bus zero", 32'(db_out), 0);
      sh_n = 1'b1; rd_n = 1'b1;
      tick(1);
      cs_n = 1'b0;
      tick(2);
      chk("R1 cs alone", 32'(coarse_stb), 0);
      cs_n = 1'b1;
      tick(1);
   endtask

   task automatic t_pulse_mode;
      mode_rd = 1'b0;
      core_result = 10'h2A5;
      cs_n = 1'b0; sh_n = 1'b0; chsel = 2'b10;
      tick(1);
      chk("R2 chan", 32'(chan), 2);
      chk("R3 coarse", 32'(coarse_stb), 1);
      chk("R3 no fine", 32'(fine_stb), 0);
      chsel = 2'b01;
      tick(3);
      chk("R2 chan held", 32'(chan), 2);
      chk("R3 coarse held", 32'(coarse_stb), 1);
      sh_n = 1'b1;
      tick(1);
      chk("R3 fine", 32'(fine_stb), 1);
      chk("R3 coarse off", 32'(coarse_stb), 0);
      tick(T1F - 1);
      chk("R3 fine last", 32'(fine_stb), 1);
      chk("R4 int before", 32'(int_n), 1);
      tick(1);
      chk("R4 int fell", 32'(int_n), 0);
      chk("R3 fine done", 32'(fine_stb), 0);
      rd_n = 1'b0;
      #1;
      chk("R7 oe", 32'(db_oe), 1);
      chk("R4 data", 32'(db_out), 32'h2A5);
      tick(2);
      chk("R6 int held", 32'(int_n), 0);
      cs_n = 1'b1;
      tick(1);
      chk("R6 int clear by cs", 32'(int_n), 1);
      chk("R7 oe off", 32'(db_oe), 0);
      chk("R7 bus zero", 32'(db_out), 0);
      rd_n = 1'b1;
      tick(1);
   endtask

   task automatic t_read_mode;
      mode_rd = 1'b1;
      core_result = 10'h13C;
      chsel = 2'b11;
      cs_n = 1'b0; sh_n = 1'b0; rd_n = 1'b0;
      #1;
      chk("R8 old data", 32'(db_out), 32'h2A5);
      tick(1);
      chk("R5 coarse", 32'(coarse_stb), 1);
      chk("R2 chan", 32'(chan), 3);
      tick(T2C - 1);
      chk("R5 coarse last", 32'(coarse_stb), 1);
      tick(1);
      chk("R5 fine", 32'(fine_stb), 1);
      chk("R8 old data mid", 32'(db_out), 32'h2A5);
      tick(T2F - 1);
      chk("R5 fine last", 32'(fine_stb), 1);
      chk("R5 int before", 32'(int_n), 1);
      chk("R8 old data late", 32'(db_out), 32'h2A5);
      tick(1);
      chk("R5 int fell", 32'(int_n), 0);
      chk("R5 new data", 32'(db_out), 32'h13C);
      sh_n = 1'b1; rd_n = 1'b1;
      tick(1);
      chk("R6 int clear", 32'(int_n), 1);
      cs_n = 1'b1;
      tick(1);
   endtask

   task automatic t_ignore_busy;
      mode_rd = 1'b1;
      core_result = 10'h3FF;
      chsel = 2'b01;
      cs_n = 1'b0; sh_n = 1'b0; rd_n = 1'b0;
      tick(2);
      sh_n = 1'b1; rd_n = 1'b1; chsel = 2'b00;
      tick(1);
      sh_n = 1'b0; rd_n = 1'b0;
      tick(1);
      chk("R9 chan kept", 32'(chan), 1);
      tick(T2C + T2F - 4);
      chk("R9 fine on time", 32'(fine_stb), 1);
      chk("R9 int before", 32'(int_n), 1);
      tick(1);
      chk("R9 int on time", 32'(int_n), 0);
      chk("R9 data", 32'(db_out), 32'h3FF);
      tick(2);
      chk("R9 no restart", 32'(coarse_stb), 0);
      chk("R9 no fine", 32'(fine_stb), 0);
      sh_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
      tick(2);
   endtask

   initial begin
      t_reset;
      t_gate_cs;
      t_pulse_mode;
      t_read_mode;
      t_ignore_busy;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule